// File: doc/BRIEF.md
# Bus-Mastering Sensor Measurement Sequencer

This block collects temperature samples without owning a converter. It acts as a bus master: on every sense tick it walks through its sensing points. For each one it replays a short list of programmed writes into a shared converter and into a sensor selector elsewhere in the chip. It then polls a programmed address until a programmed valid bit shows, and stores the returned data word in that point's result register. All addresses, write values, the valid-bit position and polarity, the data shift, the per-point selector codes and the timing counts are static configuration inputs, held by a register file outside the block.

The time base is a unit of `(cfg_div + 1) * UNIT_CLKS` clocks (256 by default). A measurement round starts every `cfg_interval` units, with 0 treated as 1. A round visits every point whose bit is set in `cfg_pt_en`, lowest index first. When a point's polling runs past `cfg_timeout` cycles without a valid word, the block pulses a timeout interrupt, leaves that point's result unchanged and moves on to the next point.

The bus port is a plain request/acknowledge master with one transaction in flight at a time.

Top module: `sensor_poll_seq`

## Requirements
- R1: While `rst_n` is low, `m_req`, `pt_new`, `irq_timeout` and every `pt_result` field are 0.
- R2: With `enable` high, measurement rounds start exactly `UNIT_CLKS * (cfg_div + 1) * max(cfg_interval, 1)` clocks apart. The bench uses `cfg_div = 1` and `cfg_interval = 3`, giving 1536.
- R3: A round measures only the points whose bit is set in `cfg_pt_en`, in ascending index order, each point once.
- R4: For each point the writes are issued in this order. First comes the point's code, zero-extended, to `cfg_sel_addr`, but only if `cfg_wr_ctl` bit 0 is set. Next comes `cfg_mux_val` to `cfg_mux_addr`, but only if `cfg_wr_ctl` bit 1 is set. Last comes `cfg_en_val` to `cfg_en_addr`, which is always issued. The code of point i is `cfg_pt_code[i*CODEW +: CODEW]`.
- R5: Polling reads `cfg_valid_addr` repeatedly. A word is valid when bit `cfg_valid_pos` of it equals `cfg_valid_high` (1 means active-high). Polling stops at the first valid word.
- R6: When `cfg_rd_sep` is 0, the valid word itself is the data. When it is 1, one read of `cfg_data_addr` follows the valid word, and that read supplies the data.
- R7: The stored result is bits [RESW-1:0] of the data word shifted right by `cfg_shift`. In the cycle after the capturing read is acknowledged, `pt_result` field i holds this value and `pt_new` bit i pulses high for exactly one cycle.
- R8: A poll read that returns not-valid while at least `cfg_timeout` cycles have passed since polling began ends the point. `irq_timeout` pulses for one cycle, no result or `pt_new` changes, and the sequencer continues with the next enabled point.
- R9: `m_addr`, `m_we` and `m_wdata` stay stable while `m_req` is high and `m_ack` is low. `m_req` is low in the cycle after an acknowledge.
- R10: With `enable` low and no round in progress, no bus request is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Runs the time base; low holds it cleared |
| cfg_div | input | DIVW | Time-unit divider |
| cfg_interval | input | INTW | Units between rounds |
| cfg_pt_en | input | NPTS | Point enable mask |
| cfg_wr_ctl | input | 2 | Bit 0 gates the selector write, bit 1 the converter mux write |
| cfg_sel_addr | input | AW | Sensor selector address |
| cfg_mux_addr | input | AW | Converter mux address |
| cfg_mux_val | input | DW | Converter mux value |
| cfg_en_addr | input | AW | Converter start address |
| cfg_en_val | input | DW | Converter start value |
| cfg_valid_addr | input | AW | Address polled for valid |
| cfg_data_addr | input | AW | Data address for separate reads |
| cfg_rd_sep | input | 1 | 0 takes valid and data from one read |
| cfg_valid_pos | input | POSW | Valid bit position |
| cfg_valid_high | input | 1 | Valid polarity, 1 is active-high |
| cfg_shift | input | POSW | Right shift applied to the data |
| cfg_timeout | input | TOW | Poll timeout in cycles |
| cfg_pt_code | input | NPTS*CODEW | Per-point selector codes |
| m_req | output | 1 | Bus request |
| m_we | output | 1 | Bus write enable |
| m_addr | output | AW | Bus address |
| m_wdata | output | DW | Bus write data |
| m_ack | input | 1 | Bus acknowledge |
| m_rdata | input | DW | Bus read data, sampled with the acknowledge |
| pt_result | output | NPTS*RESW | Per-point results |
| pt_new | output | NPTS | Per-point new-data pulse |
| irq_timeout | output | 1 | Poll timeout pulse |

## Verification
A wrong point index or pending mask shows up at the first `pt_new` of the round: either the pulse lands on a bit outside the enable order, or the stored value belongs to a different bus read. A sequencer that leaves a write state too early or too late changes the write list that the bus model logs before the first poll read, so the error is seen in that same point. A wrong valid decision changes the number of poll reads counted before capture, or stores the not-valid word, and either is reported when that point's `pt_new` appears. A time-base error moves the spacing between converter-start writes and is seen after two rounds.

// File: rtl/sms_pkg.sv
package sms_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PICK,
      ST_WSEL,
      ST_WMUX,
      ST_WEN,
      ST_POLL,
      ST_RDAT
   } seq_state_e;

   localparam int SMS_UNIT_DEFAULT = 256;
endpackage

// File: rtl/sms_timebase.sv
module sms_timebase #(
   parameter int DIVW = 8,
   parameter int INTW = 12,
   parameter int UNIT = 256
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            run,
   input  logic [DIVW-1:0] div,
   input  logic [INTW-1:0] interval,
   output logic            tick
);
   localparam int PREW = (UNIT > 1) ? $clog2(UNIT) : 1;

   if (UNIT < 2) begin : g_bad_unit
      $error("sms_timebase: UNIT must be at least 2");
   end

   logic [PREW-1:0] pre;
   logic [DIVW-1:0] dcnt;
   logic [INTW-1:0] icnt;
   logic [INTW-1:0] last;
   logic            pre_end, unit_end, int_end;

   assign last     = (interval == '0) ? '0 : interval - INTW'(1);
   assign pre_end  = (pre == PREW'(UNIT - 1));
   assign unit_end = pre_end && (dcnt == div);
   assign int_end  = (icnt >= last);
   assign tick     = run && unit_end && int_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre  <= '0;
         dcnt <= '0;
         icnt <= '0;
      end else if (!run) begin
         pre  <= '0;
         dcnt <= '0;
         icnt <= '0;
      end else begin
         pre <= pre_end ? '0 : pre + PREW'(1);
         if (pre_end) dcnt <= (dcnt == div) ? '0 : dcnt + DIVW'(1);
         if (unit_end) icnt <= int_end ? '0 : icnt + INTW'(1);
      end
   end

   // R2: a unit lasts at least UNIT clocks, so ticks never come back to back
   a_r2_tick_spacing : assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);
endmodule

// File: rtl/sms_busm.sv
module sms_busm #(
   parameter int AW = 32,
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          we,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   output logic          done,
   output logic          m_req,
   output logic          m_we,
   output logic [AW-1:0] m_addr,
   output logic [DW-1:0] m_wdata,
   input  logic          m_ack
);
   assign done = m_req && m_ack;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_req   <= 1'b0;
         m_we    <= 1'b0;
         m_addr  <= '0;
         m_wdata <= '0;
      end else if (m_req && m_ack) begin
         m_req <= 1'b0;
      end else if (start && !m_req) begin
         m_req   <= 1'b1;
         m_we    <= we;
         m_addr  <= addr;
         m_wdata <= wdata;
      end
   end

   a_r9_hold_request : assert property (@(posedge clk) disable iff (!rst_n)
      (m_req && !m_ack) |=> (m_req && $stable(m_addr) && $stable(m_we) && $stable(m_wdata)));

   a_r9_release_after_ack : assert property (@(posedge clk) disable iff (!rst_n)
      (m_req && m_ack) |=> !m_req);
endmodule

// File: rtl/sms_seq.sv
module sms_seq
   import sms_pkg::*;
#(
   parameter int NPTS  = 4,
   parameter int AW    = 32,
   parameter int DW    = 32,
   parameter int CODEW = 8,
   parameter int RESW  = 12,
   parameter int TOW   = 16,
   parameter int POSW  = 5,
   parameter int IDXW  = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  run,
   input  logic                  tick,
   input  logic [NPTS-1:0]       cfg_pt_en,
   input  logic [1:0]            cfg_wr_ctl,
   input  logic [AW-1:0]         cfg_sel_addr,
   input  logic [AW-1:0]         cfg_mux_addr,
   input  logic [DW-1:0]         cfg_mux_val,
   input  logic [AW-1:0]         cfg_en_addr,
   input  logic [DW-1:0]         cfg_en_val,
   input  logic [AW-1:0]         cfg_valid_addr,
   input  logic [AW-1:0]         cfg_data_addr,
   input  logic                  cfg_rd_sep,
   input  logic [POSW-1:0]       cfg_valid_pos,
   input  logic                  cfg_valid_high,
   input  logic [POSW-1:0]       cfg_shift,
   input  logic [TOW-1:0]        cfg_timeout,
   input  logic [NPTS*CODEW-1:0] cfg_pt_code,
   output logic                  bm_start,
   output logic                  bm_we,
   output logic [AW-1:0]         bm_addr,
   output logic [DW-1:0]         bm_wdata,
   input  logic                  bm_done,
   input  logic [DW-1:0]         bm_rdata,
   output logic [NPTS*RESW-1:0]  pt_result,
   output logic [NPTS-1:0]       pt_new,
   output logic                  irq_timeout
);
   seq_state_e       st;
   seq_state_e       first_wr;
   logic [NPTS-1:0]  pend;
   logic [IDXW-1:0]  idx, nxt_idx;
   logic             launched, bus_state;
   logic [TOW-1:0]   tocnt;
   logic             is_valid, cap_fire, to_fire;
   logic [DW-1:0]    shifted;
   logic [RESW-1:0]  cap_val;
   logic [CODEW-1:0] code_a [NPTS];
   logic [RESW-1:0]  res_q  [NPTS];

   // lowest pending point wins
   always_comb begin
      nxt_idx = '0;
      for (int i = NPTS - 1; i >= 0; i--) begin
         if (pend[i]) nxt_idx = IDXW'(i);
      end
   end

   assign first_wr  = cfg_wr_ctl[0] ? ST_WSEL : (cfg_wr_ctl[1] ? ST_WMUX : ST_WEN);
   assign is_valid  = (bm_rdata[cfg_valid_pos] == cfg_valid_high);
   assign shifted   = bm_rdata >> cfg_shift;
   assign cap_val   = shifted[RESW-1:0];
   assign cap_fire  = bm_done && (((st == ST_POLL) && is_valid && !cfg_rd_sep) || (st == ST_RDAT));
   assign to_fire   = bm_done && (st == ST_POLL) && !is_valid && (tocnt >= cfg_timeout);
   assign bus_state = (st == ST_WSEL) || (st == ST_WMUX) || (st == ST_WEN) ||
                      (st == ST_POLL) || (st == ST_RDAT);
   assign bm_start  = bus_state && !launched;

   always_comb begin
      bm_we    = 1'b0;
      bm_addr  = cfg_valid_addr;
      bm_wdata = '0;
      case (st)
         ST_WSEL: begin
            bm_we    = 1'b1;
            bm_addr  = cfg_sel_addr;
            bm_wdata = DW'(code_a[idx]);
         end
         ST_WMUX: begin
            bm_we    = 1'b1;
            bm_addr  = cfg_mux_addr;
            bm_wdata = cfg_mux_val;
         end
         ST_WEN: begin
            bm_we    = 1'b1;
            bm_addr  = cfg_en_addr;
            bm_wdata = cfg_en_val;
         end
         ST_RDAT: bm_addr = cfg_data_addr;
         default: bm_addr = cfg_valid_addr;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st          <= ST_IDLE;
         pend        <= '0;
         idx         <= '0;
         launched    <= 1'b0;
         tocnt       <= '0;
         pt_new      <= '0;
         irq_timeout <= 1'b0;
      end else begin
         pt_new      <= cap_fire ? (NPTS'(1) << idx) : '0;
         irq_timeout <= to_fire;
         if (bm_start) launched <= 1'b1;
         if (bm_done)  launched <= 1'b0;
         if ((st == ST_POLL) && (tocnt != '1)) tocnt <= tocnt + TOW'(1);
         case (st)
            ST_IDLE: if (tick && (cfg_pt_en != '0)) begin
               pend <= cfg_pt_en;
               st   <= ST_PICK;
            end
            ST_PICK: if (pend == '0) begin
               st <= ST_IDLE;
            end else begin
               idx           <= nxt_idx;
               pend[nxt_idx] <= 1'b0;
               st            <= first_wr;
            end
            ST_WSEL: if (bm_done) st <= cfg_wr_ctl[1] ? ST_WMUX : ST_WEN;
            ST_WMUX: if (bm_done) st <= ST_WEN;
            ST_WEN: if (bm_done) begin
               st    <= ST_POLL;
               tocnt <= '0;
            end
            ST_POLL: if (bm_done) begin
               if (is_valid)    st <= cfg_rd_sep ? ST_RDAT : ST_PICK;
               else if (to_fire) st <= ST_PICK;
            end
            ST_RDAT: if (bm_done) st <= ST_PICK;
            default: st <= ST_IDLE;
         endcase
      end
   end

   for (genvar g = 0; g < NPTS; g++) begin : g_pt
      assign code_a[g] = cfg_pt_code[g*CODEW +: CODEW];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                res_q[g] <= '0;
         else if (cap_fire && (idx == IDXW'(g)))    res_q[g] <= cap_val;
      end
      assign pt_result[g*RESW +: RESW] = res_q[g];
   end

   a_r7_single_point_strobe : assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(pt_new));

   a_r8_timeout_excludes_capture : assert property (@(posedge clk) disable iff (!rst_n)
      !(irq_timeout && (pt_new != '0)));

   a_r10_stay_idle_when_off : assert property (@(posedge clk) disable iff (!rst_n)
      ((st == ST_IDLE) && !run) |=> (st == ST_IDLE));

   a_r9_one_launch_per_op : assert property (@(posedge clk) disable iff (!rst_n)
      bm_start |=> !bm_start);
endmodule

// File: rtl/sensor_poll_seq.sv
module sensor_poll_seq
   import sms_pkg::*;
#(
   parameter int NPTS      = 4,
   parameter int AW        = 32,
   parameter int DW        = 32,
   parameter int CODEW     = 8,
   parameter int RESW      = 12,
   parameter int DIVW      = 8,
   parameter int INTW      = 12,
   parameter int TOW       = 16,
   parameter int UNIT_CLKS = SMS_UNIT_DEFAULT,
   localparam int POSW     = $clog2(DW),
   localparam int IDXW     = (NPTS > 1) ? $clog2(NPTS) : 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  enable,
   input  logic [DIVW-1:0]       cfg_div,
   input  logic [INTW-1:0]       cfg_interval,
   input  logic [NPTS-1:0]       cfg_pt_en,
   input  logic [1:0]            cfg_wr_ctl,
   input  logic [AW-1:0]         cfg_sel_addr,
   input  logic [AW-1:0]         cfg_mux_addr,
   input  logic [DW-1:0]         cfg_mux_val,
   input  logic [AW-1:0]         cfg_en_addr,
   input  logic [DW-1:0]         cfg_en_val,
   input  logic [AW-1:0]         cfg_valid_addr,
   input  logic [AW-1:0]         cfg_data_addr,
   input  logic                  cfg_rd_sep,
   input  logic [POSW-1:0]       cfg_valid_pos,
   input  logic                  cfg_valid_high,
   input  logic [POSW-1:0]       cfg_shift,
   input  logic [TOW-1:0]        cfg_timeout,
   input  logic [NPTS*CODEW-1:0] cfg_pt_code,
   output logic                  m_req,
   output logic                  m_we,
   output logic [AW-1:0]         m_addr,
   output logic [DW-1:0]         m_wdata,
   input  logic                  m_ack,
   input  logic [DW-1:0]         m_rdata,
   output logic [NPTS*RESW-1:0]  pt_result,
   output logic [NPTS-1:0]       pt_new,
   output logic                  irq_timeout
);
   if (NPTS < 1 || NPTS > 16) begin : g_bad_npts
      $error("sensor_poll_seq: NPTS out of range");
   end
   if (RESW > DW || CODEW > DW) begin : g_bad_width
      $error("sensor_poll_seq: RESW and CODEW must fit in DW");
   end
   if ((1 << POSW) != DW) begin : g_bad_dw
      $error("sensor_poll_seq: DW must be a power of two");
   end

   logic          tick;
   logic          bm_start, bm_we, bm_done;
   logic [AW-1:0] bm_addr;
   logic [DW-1:0] bm_wdata;

   sms_timebase #(.DIVW(DIVW), .INTW(INTW), .UNIT(UNIT_CLKS)) u_tb (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (enable),
      .div      (cfg_div),
      .interval (cfg_interval),
      .tick     (tick)
   );

   sms_seq #(
      .NPTS(NPTS), .AW(AW), .DW(DW), .CODEW(CODEW), .RESW(RESW),
      .TOW(TOW), .POSW(POSW), .IDXW(IDXW)
   ) u_seq (
      .clk            (clk),
      .rst_n          (rst_n),
      .run            (enable),
      .tick           (tick),
      .cfg_pt_en      (cfg_pt_en),
      .cfg_wr_ctl     (cfg_wr_ctl),
      .cfg_sel_addr   (cfg_sel_addr),
      .cfg_mux_addr   (cfg_mux_addr),
      .cfg_mux_val    (cfg_mux_val),
      .cfg_en_addr    (cfg_en_addr),
      .cfg_en_val     (cfg_en_val),
      .cfg_valid_addr (cfg_valid_addr),
      .cfg_data_addr  (cfg_data_addr),
      .cfg_rd_sep     (cfg_rd_sep),
      .cfg_valid_pos  (cfg_valid_pos),
      .cfg_valid_high (cfg_valid_high),
      .cfg_shift      (cfg_shift),
      .cfg_timeout    (cfg_timeout),
      .cfg_pt_code    (cfg_pt_code),
      .bm_start       (bm_start),
      .bm_we          (bm_we),
      .bm_addr        (bm_addr),
      .bm_wdata       (bm_wdata),
      .bm_done        (bm_done),
      .bm_rdata       (m_rdata),
      .pt_result      (pt_result),
      .pt_new         (pt_new),
      .irq_timeout    (irq_timeout)
   );

   sms_busm #(.AW(AW), .DW(DW)) u_bus (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (bm_start),
      .we      (bm_we),
      .addr    (bm_addr),
      .wdata   (bm_wdata),
      .done    (bm_done),
      .m_req   (m_req),
      .m_we    (m_we),
      .m_addr  (m_addr),
      .m_wdata (m_wdata),
      .m_ack   (m_ack)
   );
endmodule

// File: tb/test_sensor_poll_seq.sv
module test_sensor_poll_seq;
   localparam int NPTS = 4;
   localparam logic [31:0] A_SEL = 32'h4000_0604;
   localparam logic [31:0] A_MUX = 32'h4100_000C;
   localparam logic [31:0] A_EN  = 32'h4100_0008;
   localparam logic [31:0] A_VLD = 32'h4100_0040;
   localparam logic [31:0] A_DAT = 32'h4100_0044;

   logic        clk = 1'b0;
   logic        rst_n, enable;
   logic [7:0]  cfg_div;
   logic [11:0] cfg_interval;
   logic [3:0]  cfg_pt_en;
   logic [1:0]  cfg_wr_ctl;
   logic [31:0] cfg_mux_val, cfg_en_val;
   logic        cfg_rd_sep, cfg_valid_high;
   logic [4:0]  cfg_valid_pos, cfg_shift;
   logic [15:0] cfg_timeout;
   logic [31:0] cfg_pt_code;
   logic        m_req, m_we, m_ack;
   logic [31:0] m_addr, m_wdata, m_rdata;
   logic [47:0] pt_result;
   logic [3:0]  pt_new, pt_new_prev;
   logic        irq_timeout;

   int nvec = 0, nerr = 0, cyc = 0;
   int ncap = 0, nirq = 0, ntx = 0;
   int conv_delay = 0, conv_left = 0, max_dly = 0, wait_left = 0;
   int valid_reads = 0, wcount = 0;
   bit stuck = 0, armed = 0, exp_data = 0;
   logic [31:0] armed_addr, armed_wdata;
   logic        armed_we;
   logic [31:0] wlog [4];
   logic [7:0]  last_code = 8'h0;
   logic [11:0] q_val [$];
   logic [7:0]  q_code [$];
   int          q_polls [$];
   int          en_time [$];

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   sensor_poll_seq i_sensor_poll_seq (
      .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_div(cfg_div),
      .cfg_interval(cfg_interval), .cfg_pt_en(cfg_pt_en), .cfg_wr_ctl(cfg_wr_ctl),
      .cfg_sel_addr(A_SEL), .cfg_mux_addr(A_MUX), .cfg_mux_val(cfg_mux_val),
      .cfg_en_addr(A_EN), .cfg_en_val(cfg_en_val), .cfg_valid_addr(A_VLD),
      .cfg_data_addr(A_DAT), .cfg_rd_sep(cfg_rd_sep), .cfg_valid_pos(cfg_valid_pos),
      .cfg_valid_high(cfg_valid_high), .cfg_shift(cfg_shift), .cfg_timeout(cfg_timeout),
      .cfg_pt_code(cfg_pt_code), .m_req(m_req), .m_we(m_we), .m_addr(m_addr),
      .m_wdata(m_wdata), .m_ack(m_ack), .m_rdata(m_rdata), .pt_result(pt_result),
      .pt_new(pt_new), .irq_timeout(irq_timeout)
   );

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      nvec++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic int popc(input logic [3:0] m);
      int n = 0;
      for (int i = 0; i < 4; i++) if (m[i]) n++;
      return n;
   endfunction

   function automatic int nth_en(input logic [3:0] m, input int n);
      int k = n;
      for (int i = 0; i < 4; i++) begin
         if (m[i]) begin
            if (k == 0) return i;
            k--;
         end
      end
      return -1;
   endfunction

   function automatic logic [31:0] make_word(input logic [31:0] raw, input logic [4:0] pos,
                                             input bit active, input bit high);
      logic [31:0] w = raw;
      w[pos] = active ? high : !high;
      return w;
   endfunction

   function automatic logic [11:0] expect_res(input logic [31:0] w, input logic [4:0] sh);
      logic [31:0] t = w >> sh;
      return t[11:0];
   endfunction

   function automatic logic [7:0] code_of(input int i);
      return cfg_pt_code[i*8 +: 8];
   endfunction

   task automatic push_cap(input logic [31:0] w);
      q_val.push_back(expect_res(w, cfg_shift));
      q_code.push_back(last_code);
      q_polls.push_back(valid_reads);
   endtask

   // bus slave modelling the shared converter
   task automatic serve();
      logic [31:0] w;
      logic [31:0] el [4];
      int k = 0;
      ntx++;
      chk(m_addr == armed_addr && m_we == armed_we && m_wdata == armed_wdata,
          "R9 request changed before ack", m_addr, armed_addr);
      if (m_we) begin
         if (wcount == 0) valid_reads = 0;
         if (wcount < 4) wlog[wcount] = m_addr;
         wcount++;
         if (m_addr == A_SEL) last_code = m_wdata[7:0];
         if (m_addr == A_MUX) chk(m_wdata == cfg_mux_val, "R4 mux value", m_wdata, cfg_mux_val);
         if (m_addr == A_EN) begin
            chk(m_wdata == cfg_en_val, "R4 start value", m_wdata, cfg_en_val);
            conv_left = conv_delay;
            en_time.push_back(cyc);
         end
      end else if (m_addr == A_VLD) begin
         if (wcount > 0) begin
            if (cfg_wr_ctl[0]) begin el[k] = A_SEL; k++; end
            if (cfg_wr_ctl[1]) begin el[k] = A_MUX; k++; end
            el[k] = A_EN; k++;
            chk(wcount == k, "R4 write count", wcount, k);
            for (int j = 0; j < k && j < wcount; j++)
               chk(wlog[j] == el[j], "R4 write order", wlog[j], el[j]);
            wcount = 0;
         end
         chk(!exp_data, "R6 data read skipped", 0, 1);
         valid_reads++;
         if (!stuck && conv_left == 0) begin
            w = make_word($urandom, cfg_valid_pos, 1'b1, cfg_valid_high);
            if (cfg_rd_sep) exp_data = 1;
            else push_cap(w);
         end else begin
            if (conv_left > 0) conv_left--;
            w = make_word($urandom, cfg_valid_pos, 1'b0, cfg_valid_high);
         end
         m_rdata = w;
      end else if (m_addr == A_DAT) begin
         chk(exp_data, "R6 unexpected data read", m_addr, A_VLD);
         w = $urandom;
         push_cap(w);
         exp_data = 0;
         m_rdata = w;
      end else begin
         chk(0, "R6 read address", m_addr, A_VLD);
      end
   endtask

   initial begin
      m_ack = 1'b0;
      m_rdata = '0;
      forever begin
         @(negedge clk);
         if (m_ack) begin
            m_ack = 1'b0;
            chk(!m_req, "R9 request held after ack", m_req, 0);
         end else if (m_req && rst_n) begin
            if (!armed) begin
               armed = 1;
               armed_addr = m_addr;
               armed_we = m_we;
               armed_wdata = m_wdata;
               wait_left = (max_dly == 0) ? 0 : int'($urandom_range(max_dly, 0));
            end
            if (wait_left > 0) wait_left--;
            else begin
               armed = 0;
               serve();
               m_ack = 1'b1;
            end
         end
      end
   end

   // result monitor
   initial begin
      int idx, eidx, p;
      logic [11:0] v;
      logic [7:0] c;
      pt_new_prev = '0;
      forever begin
         @(negedge clk);
         if (rst_n) begin
            if (irq_timeout) nirq++;
            if (pt_new != '0) begin
               chk($countones(pt_new) == 1, "R7 strobe one-hot", pt_new, 1);
               chk(pt_new != pt_new_prev, "R7 strobe longer than one cycle", pt_new, 0);
               idx = 0;
               for (int i = 3; i >= 0; i--) if (pt_new[i]) idx = i;
               eidx = nth_en(cfg_pt_en, ncap % popc(cfg_pt_en));
               chk(idx == eidx, "R3 point order", idx, eidx);
               if (q_val.size() == 0) begin
                  chk(0, "R7 strobe without capture", pt_new, 0);
               end else begin
                  v = q_val.pop_front();
                  c = q_code.pop_front();
                  p = q_polls.pop_front();
                  chk(pt_result[idx*12 +: 12] == v, "R7 stored value", pt_result[idx*12 +: 12], v);
                  if (cfg_wr_ctl[0]) chk(c == code_of(idx), "R4 selector code", c, code_of(idx));
                  chk(p == conv_delay + 1, "R5 poll count", p, conv_delay + 1);
               end
               ncap++;
            end
            pt_new_prev = pt_new;
         end
      end
   end

   task automatic wait_caps(input int n, input string tag);
      int t = 0;
      while (ncap < n && t < 20000) begin
         @(negedge clk);
         t++;
      end
      chk(ncap >= n, tag, ncap, n);
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      nerr++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      logic [47:0] snap;
      int n0, t;
      rst_n = 1'b0;
      enable = 1'b0;
      cfg_div = 8'd0;
      cfg_interval = 12'd1;
      cfg_pt_en = 4'hF;
      cfg_wr_ctl = 2'b11;
      cfg_mux_val = 32'h0000_0800;
      cfg_en_val = 32'h0000_0800;
      cfg_rd_sep = 1'b0;
      cfg_valid_high = 1'b1;
      cfg_valid_pos = 5'd12;
      cfg_shift = 5'd0;
      cfg_timeout = 16'hFFFF;
      cfg_pt_code = 32'h1003_0201;
      void'($urandom(32'd1234));

      repeat (4) @(negedge clk);
      chk(m_req == 1'b0, "R1 request in reset", m_req, 0);
      chk(pt_new == '0, "R1 strobe in reset", pt_new, 0);
      chk(irq_timeout == 1'b0, "R1 interrupt in reset", irq_timeout, 0);
      chk(pt_result == '0, "R1 results in reset", pt_result, 0);
      rst_n = 1'b1;

      // directed: all points, single read, active-high at bit 12
      conv_delay = 2;
      max_dly = 2;
      ncap = 0;
      nirq = 0;
      enable = 1'b1;
      wait_caps(8, "R3 directed rounds complete");
      enable = 1'b0;
      chk(nirq == 0, "R8 no spurious timeout", nirq, 0);
      repeat (4) @(negedge clk);

      // constrained random configurations
      for (int r = 0; r < 12; r++) begin
         cfg_pt_en = 4'($urandom_range(15, 1));
         cfg_wr_ctl = 2'($urandom_range(3, 0));
         cfg_valid_pos = 5'($urandom_range(31, 0));
         cfg_valid_high = 1'($urandom_range(1, 0));
         cfg_shift = 5'($urandom_range(20, 0));
         cfg_rd_sep = 1'($urandom_range(1, 0));
         cfg_pt_code = $urandom;
         cfg_mux_val = $urandom;
         cfg_en_val = $urandom;
         conv_delay = int'($urandom_range(4, 0));
         max_dly = int'($urandom_range(3, 0));
         ncap = 0;
         nirq = 0;
         enable = 1'b1;
         wait_caps(2 * popc(cfg_pt_en), "R5 R6 random rounds complete");
         enable = 1'b0;
         chk(nirq == 0, "R8 no spurious timeout", nirq, 0);
         repeat (4) @(negedge clk);
      end

      // timeout: converter never reports valid on points 0 and 2
      cfg_pt_en = 4'b0101;
      cfg_wr_ctl = 2'b11;
      cfg_rd_sep = 1'b0;
      cfg_timeout = 16'd20;
      conv_delay = 0;
      max_dly = 1;
      stuck = 1;
      snap = pt_result;
      ncap = 0;
      nirq = 0;
      enable = 1'b1;
      t = 0;
      while (nirq < 2 && t < 5000) begin
         @(negedge clk);
         t++;
      end
      repeat (30) @(negedge clk);
      chk(nirq == 2, "R8 one timeout per point", nirq, 2);
      chk(ncap == 0, "R8 no capture on timeout", ncap, 0);
      chk(pt_result == snap, "R8 results kept on timeout", pt_result, snap);
      stuck = 0;
      wait_caps(2, "R8 recovery after timeout");
      enable = 1'b0;
      repeat (4) @(negedge clk);

      // round spacing
      cfg_pt_en = 4'b0001;
      cfg_timeout = 16'hFFFF;
      cfg_div = 8'd1;
      cfg_interval = 12'd3;
      max_dly = 0;
      conv_delay = 1;
      en_time.delete();
      ncap = 0;
      enable = 1'b1;
      wait_caps(3, "R2 rounds complete");
      enable = 1'b0;
      chk(en_time.size() == 3, "R2 round count", en_time.size(), 3);
      if (en_time.size() == 3) begin
         chk(en_time[1] - en_time[0] == 1536, "R2 round spacing", en_time[1] - en_time[0], 1536);
         chk(en_time[2] - en_time[1] == 1536, "R2 round spacing", en_time[2] - en_time[1], 1536);
      end

      // disabled: no bus traffic
      repeat (10) @(negedge clk);
      n0 = ntx;
      repeat (3000) @(negedge clk);
      chk(ntx == n0, "R10 traffic while disabled", ntx - n0, 0);
      chk(m_req == 1'b0, "R10 request while disabled", m_req, 0);

      finish_run();
   end
endmodule